// File: doc/BRIEF.md
# Intra 16x16 Luma Mode Selector

This block chooses the intra prediction mode for one 16x16 luma macroblock. Software or an upstream loader first fills two local stores. One is a 32-entry neighbour store: entries 0..15 hold the row above the macroblock and entries 16..31 hold the column to its left. The other is a 256-entry store of original samples. The top-left corner neighbour comes in on its own input. A start pulse carries a 2-bit availability code. The block then works through the legal candidate modes one at a time. For each mode it streams 256 residuals (original minus prediction) to an external cost unit over a valid/ready channel, then waits for that unit to return one cost value.

Two residual buffers work as a ping-pong pair. Each finished candidate is compared with the best so far, using cost alone. The next candidate overwrites whichever buffer holds the losing residuals, so the winner's residuals are never copied. When the last candidate is scored, the block reports the winning mode and the buffer that holds it. The next stage reads that buffer through a random-access read port.

The residual stream follows the usual valid/ready rules. A transfer happens on a rising clock edge where both valid and ready are high. While valid is high and ready is low, the data and the last flag hold steady. Valid never drops without a transfer. The consumer may hold ready low for any number of cycles.

Top module: `intra16_mode_sel`

## Requirements
- R1: A start pulse while `busy` is low captures `avail` and begins the first candidate, so `busy` and `res_valid` are high on the next cycle. A start pulse while `busy` is high is ignored, and the sequence in progress continues unchanged.
- R2: In `avail`, bit 1 means the upper neighbours are present and bit 0 means the left neighbours are present. The candidate order is: code 11 gives DC, Horizontal, Vertical, Plane; code 10 gives DC, Vertical; code 01 gives DC, Horizontal; code 00 gives DC alone. Mode codes are Vertical=0, Horizontal=1, DC=2, Plane=3.
- R3: DC prediction is computed from the neighbour sums. With both sides present it is (upper sum + left sum + 16) >> 5. With one side present it is (that side's sum + 8) >> 4. With neither side present it is 128.
- R4: Horizontal prediction at row y is left neighbour y (store entry 16+y). Vertical prediction at column x is upper neighbour x (store entry x).
- R5: Plane prediction computes H = sum over i=0..7 of (i+1)*(U[8+i] - U[6-i]) and V the same way over the left column, with U[-1] and L[-1] both taken as the corner input. Then b=(5H+32)>>6, c=(5V+32)>>6 and a=16*(L[15]+U[15]). The prediction is (a + b(x-7) + c(y-7) + 16) >> 5, using arithmetic shifts and clipped to 0..255.
- R6: Each candidate emits exactly 256 residuals, and `res_last` is high only on the 256th. A residual is the 9-bit two's-complement value original minus prediction. Stream index k visits 4x4 blocks in raster order: x = {k[5:4],k[1:0]} and y = {k[7:6],k[3:2]}. The original sample for (x,y) is at original-store address y*16+x.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_last` hold their values into the next cycle.
- R8: After a candidate's 256th transfer, the block waits for a `cost_valid` pulse. A candidate replaces the best so far only if its cost is strictly lower, so on equal cost the earlier mode wins.
- R9: The first candidate's residuals go to buffer 0. Each later candidate writes the buffer that does not hold the current best. `best_buf` names the buffer holding the winner. `rd_data` returns entry `rd_addr` of that buffer, combinationally, in the same index order as the stream.
- R10: `done` is high for exactly one cycle after the last cost is taken, and `busy` is low on the cycle after that. `best_mode` and `best_buf` then hold until the next accepted start. After reset, `best_mode` reads DC (2) and `best_buf` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_we | input | 1 | Neighbour store write enable |
| ref_waddr | input | 5 | Neighbour store address (0..15 upper, 16..31 left) |
| ref_wdata | input | 8 | Neighbour sample |
| org_we | input | 1 | Original store write enable |
| org_waddr | input | 8 | Original store address, row*16+column |
| org_wdata | input | 8 | Original sample |
| nb_corner | input | 8 | Top-left corner neighbour, used by Plane |
| start | input | 1 | Start pulse |
| avail | input | 2 | Neighbour availability code, captured at start |
| busy | output | 1 | Sequence in progress |
| res_valid | output | 1 | Residual stream valid |
| res_ready | input | 1 | Residual stream ready |
| res_data | output | 9 | Signed residual |
| res_last | output | 1 | Marks the 256th residual of a candidate |
| cost_valid | input | 1 | Cost return strobe |
| cost_data | input | 16 | Cost of the candidate just streamed |
| done | output | 1 | One-cycle completion pulse |
| best_mode | output | 2 | Winning mode code |
| best_buf | output | 1 | Buffer holding the winning residuals |
| rd_addr | input | 8 | Readout index into the winning buffer |
| rd_data | output | 9 | Readout residual |

## Verification
The residual stream is checked against an independent predictor under all four availability codes. A smooth-gradient neighbour set shows whether each mode is computed and placed correctly. A steep, opposing-gradient set drives Plane prediction past both clip limits, which exposes a wrong shift or a missing clamp. The cost sequences cover a late winner, an early winner, and all-equal costs. Together they separate strict from non-strict comparison and show whether the ping-pong buffer was steered correctly, which is confirmed by reading the winner back. A stuttering ready pattern and a start pulse in the middle of a run show that back-pressure and busy-time starts do not disturb the index order or the mode sequence.

// File: rtl/intra16_pkg.sv
package intra16_pkg;
  localparam int MB_DIM = 16;
  localparam int MB_PIX = MB_DIM * MB_DIM;

  typedef enum logic [1:0] {
    M_VERT  = 2'd0,
    M_HOR   = 2'd1,
    M_DC    = 2'd2,
    M_PLANE = 2'd3
  } imode_e;
endpackage

// File: rtl/intra16_order.sv
// Candidate sequence for a given neighbour availability code.
module intra16_order
  import intra16_pkg::*;
(
  input  logic [1:0] avail,
  input  logic [1:0] idx,
  output imode_e     mode,
  output logic [2:0] count
);
  always_comb begin
    mode  = M_DC;
    count = 3'd1;
    unique case (avail)
      2'b11: begin
        count = 3'd4;
        unique case (idx)
          2'd0: mode = M_DC;
          2'd1: mode = M_HOR;
          2'd2: mode = M_VERT;
          default: mode = M_PLANE;
        endcase
      end
      2'b10: begin
        count = 3'd2;
        mode  = (idx == 2'd0) ? M_DC : M_VERT;
      end
      2'b01: begin
        count = 3'd2;
        mode  = (idx == 2'd0) ? M_DC : M_HOR;
      end
      default: begin
        count = 3'd1;
        mode  = M_DC;
      end
    endcase
  end
endmodule

// File: rtl/intra16_pred.sv
// Per-sample predictor for the four 16x16 luma modes.
module intra16_pred
  import intra16_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [MB_DIM*PIX_W-1:0] top_px,
  input  logic [MB_DIM*PIX_W-1:0] left_px,
  input  logic [PIX_W-1:0]        corner,
  input  logic [1:0]              avail,
  input  imode_e                  mode,
  input  logic [3:0]              x,
  input  logic [3:0]              y,
  output logic [PIX_W-1:0]        pred
);
  localparam int HALF  = MB_DIM / 2;
  localparam int PMAX  = (1 << PIX_W) - 1;
  localparam int MID   = 1 << (PIX_W - 1);

  int sum_t, sum_l, dc_v, h_acc, v_acc, b_v, c_v, a_v, pl_v, far_t, far_l;

  always_comb begin
    sum_t = 0;
    sum_l = 0;
    h_acc = 0;
    v_acc = 0;
    for (int i = 0; i < MB_DIM; i++) begin
      sum_t = sum_t + int'(top_px[i*PIX_W +: PIX_W]);
      sum_l = sum_l + int'(left_px[i*PIX_W +: PIX_W]);
    end
    for (int i = 0; i < HALF; i++) begin
      far_t = (i == HALF - 1) ? int'(corner) : int'(top_px[(HALF-2-i)*PIX_W +: PIX_W]);
      far_l = (i == HALF - 1) ? int'(corner) : int'(left_px[(HALF-2-i)*PIX_W +: PIX_W]);
      h_acc = h_acc + (i + 1) * (int'(top_px[(HALF+i)*PIX_W +: PIX_W]) - far_t);
      v_acc = v_acc + (i + 1) * (int'(left_px[(HALF+i)*PIX_W +: PIX_W]) - far_l);
    end
    unique case (avail)
      2'b11:   dc_v = (sum_t + sum_l + 16) >>> 5;
      2'b10:   dc_v = (sum_t + 8) >>> 4;
      2'b01:   dc_v = (sum_l + 8) >>> 4;
      default: dc_v = MID;
    endcase
    b_v  = (5 * h_acc + 32) >>> 6;
    c_v  = (5 * v_acc + 32) >>> 6;
    a_v  = 16 * (int'(left_px[(MB_DIM-1)*PIX_W +: PIX_W]) + int'(top_px[(MB_DIM-1)*PIX_W +: PIX_W]));
    pl_v = (a_v + b_v * (int'(x) - 7) + c_v * (int'(y) - 7) + 16) >>> 5;
    if (pl_v < 0)    pl_v = 0;
    if (pl_v > PMAX) pl_v = PMAX;

    unique case (mode)
      M_DC:    pred = PIX_W'(dc_v);
      M_HOR:   pred = left_px[int'(y)*PIX_W +: PIX_W];
      M_VERT:  pred = top_px[int'(x)*PIX_W +: PIX_W];
      default: pred = PIX_W'(pl_v);
    endcase
  end
endmodule

// File: rtl/intra16_resbuf.sv
// One residual buffer: synchronous write, combinational read.
module intra16_resbuf #(
  parameter int W     = 9,
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/intra16_mode_sel.sv
module intra16_mode_sel
  import intra16_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COST_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ref_we,
  input  logic [$clog2(2*MB_DIM)-1:0]   ref_waddr,
  input  logic [PIX_W-1:0]              ref_wdata,
  input  logic                          org_we,
  input  logic [$clog2(MB_PIX)-1:0]     org_waddr,
  input  logic [PIX_W-1:0]              org_wdata,
  input  logic [PIX_W-1:0]              nb_corner,
  input  logic                          start,
  input  logic [1:0]                    avail,
  output logic                          busy,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [PIX_W:0]                res_data,
  output logic                          res_last,
  input  logic                          cost_valid,
  input  logic [COST_W-1:0]             cost_data,
  output logic                          done,
  output logic [1:0]                    best_mode,
  output logic                          best_buf,
  input  logic [$clog2(MB_PIX)-1:0]     rd_addr,
  output logic [PIX_W:0]                rd_data
);
  localparam int RES_W = PIX_W + 1;
  localparam int AW    = $clog2(MB_PIX);
  localparam int NBUF  = 2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_COST, S_FIN} state_e;

  state_e               state;
  logic [1:0]           av_q;
  logic [1:0]           idx;
  logic [AW-1:0]        pos;
  logic                 wr_sel;
  imode_e               best_mode_q;
  logic                 best_buf_q;
  logic [COST_W-1:0]    best_cost;

  logic [PIX_W-1:0]     ref_mem [2*MB_DIM];
  logic [PIX_W-1:0]     org_mem [MB_PIX];
  logic [MB_DIM*PIX_W-1:0] top_px, left_px;

  imode_e               cur_mode;
  logic [2:0]           mode_cnt;
  logic [3:0]           px, py;
  logic [PIX_W-1:0]     pred, orig;
  logic [RES_W-1:0]     resid;
  logic                 xfer, win, last_mode;
  logic [RES_W-1:0]     buf_rd [NBUF];

  always_ff @(posedge clk) begin
    if (ref_we) ref_mem[ref_waddr] <= ref_wdata;
    if (org_we) org_mem[org_waddr] <= org_wdata;
  end

  for (genvar g = 0; g < MB_DIM; g++) begin : g_pack
    assign top_px[g*PIX_W +: PIX_W]  = ref_mem[g];
    assign left_px[g*PIX_W +: PIX_W] = ref_mem[g + MB_DIM];
  end

  intra16_order u_order (
    .avail (av_q),
    .idx   (idx),
    .mode  (cur_mode),
    .count (mode_cnt)
  );

  // 4x4 blocks in raster order, samples raster order inside each block
  assign px = {pos[5:4], pos[1:0]};
  assign py = {pos[7:6], pos[3:2]};

  intra16_pred #(.PIX_W(PIX_W)) u_pred (
    .top_px  (top_px),
    .left_px (left_px),
    .corner  (nb_corner),
    .avail   (av_q),
    .mode    (cur_mode),
    .x       (px),
    .y       (py),
    .pred    (pred)
  );

  assign orig  = org_mem[{py, px}];
  assign resid = {1'b0, orig} - {1'b0, pred};

  assign res_valid = (state == S_RUN);
  assign res_data  = resid;
  assign res_last  = (pos == AW'(MB_PIX - 1));
  assign xfer      = res_valid && res_ready;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign best_mode = best_mode_q;
  assign best_buf  = best_buf_q;
  assign win       = (idx == 2'd0) || (cost_data < best_cost);
  assign last_mode = ({1'b0, idx} == mode_cnt - 3'd1);

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    intra16_resbuf #(.W(RES_W), .DEPTH(MB_PIX)) u_buf (
      .clk   (clk),
      .we    (xfer && (wr_sel == 1'(b))),
      .waddr (pos),
      .wdata (resid),
      .raddr (rd_addr),
      .rdata (buf_rd[b])
    );
  end

  assign rd_data = buf_rd[best_buf_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      av_q        <= 2'b00;
      idx         <= 2'd0;
      pos         <= '0;
      wr_sel      <= 1'b0;
      best_mode_q <= M_DC;
      best_buf_q  <= 1'b0;
      best_cost   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          av_q   <= avail;
          idx    <= 2'd0;
          pos    <= '0;
          wr_sel <= 1'b0;
          state  <= S_RUN;
        end
        S_RUN: if (xfer) begin
          pos <= pos + AW'(1);
          if (res_last) state <= S_COST;
        end
        S_COST: if (cost_valid) begin
          if (win) begin
            best_cost   <= cost_data;
            best_mode_q <= cur_mode;
            best_buf_q  <= wr_sel;
            wr_sel      <= ~wr_sel;
          end else begin
            wr_sel      <= ~best_buf_q;
          end
          if (last_mode) state <= S_FIN;
          else begin
            idx   <= idx + 2'd1;
            state <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intra16_mode_sel_chk.sv
module intra16_mode_sel_chk #(
  parameter int RES_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       avail,
  input logic             busy,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic             res_last,
  input logic             done,
  input logic [1:0]       best_mode,
  input logic             best_buf
);
  logic [7:0] hs_cnt;
  logic [1:0] av_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt <= 8'd0;
      av_cap <= 2'b00;
    end else begin
      if (res_valid && res_ready) hs_cnt <= hs_cnt + 8'd1;
      if (start && !busy) av_cap <= avail;
    end
  end

  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && res_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_last));

  a_r6_last_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_last |-> hs_cnt == 8'hFF);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(best_mode) && $stable(best_buf));

  a_r2_dc_only: assert property (@(posedge clk) disable iff (!rst_n)
    done && av_cap == 2'b00 |-> best_mode == 2'd2);

  a_r2_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
    done && av_cap == 2'b10 |-> best_mode == 2'd2 || best_mode == 2'd0);

  a_r2_left_only: assert property (@(posedge clk) disable iff (!rst_n)
    done && av_cap == 2'b01 |-> best_mode == 2'd2 || best_mode == 2'd1);
endmodule

bind intra16_mode_sel intra16_mode_sel_chk #(.RES_W(PIX_W + 1)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .avail     (avail),
  .busy      (busy),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_last  (res_last),
  .done      (done),
  .best_mode (best_mode),
  .best_buf  (best_buf)
);

// File: tb/sim_intra16_mode_sel.sv
`timescale 1ns/1ps
module sim_intra16_mode_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_we = 1'b0;
  logic [4:0] ref_waddr = '0;
  logic [7:0] ref_wdata = '0;
  logic       org_we = 1'b0;
  logic [7:0] org_waddr = '0;
  logic [7:0] org_wdata = '0;
  logic [7:0] nb_corner = '0;
  logic       start = 1'b0;
  logic [1:0] avail = '0;
  logic       busy, res_valid, res_last, done, best_buf;
  logic       res_ready = 1'b0;
  logic [8:0] res_data, rd_data;
  logic       cost_valid = 1'b0;
  logic [15:0] cost_data = '0;
  logic [1:0] best_mode;
  logic [7:0] rd_addr = '0;

  int n_chk = 0;
  int n_bad = 0;
  int tp[16], lp[16], cn, org[256];
  int resv[4][256];

  always #10 clk = ~clk;

  intra16_mode_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .ref_we(ref_we), .ref_waddr(ref_waddr), .ref_wdata(ref_wdata),
    .org_we(org_we), .org_waddr(org_waddr), .org_wdata(org_wdata),
    .nb_corner(nb_corner), .start(start), .avail(avail), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_last(res_last),
    .cost_valid(cost_valid), .cost_data(cost_data), .done(done),
    .best_mode(best_mode), .best_buf(best_buf), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2 candidate order and mode codes
  function automatic int mode_cnt(int av);
    return (av == 3) ? 4 : (av == 0) ? 1 : 2;
  endfunction
  function automatic int mode_at(int av, int i);
    if (i == 0) return 2;
    if (av == 3) return (i == 1) ? 1 : (i == 2) ? 0 : 3;
    return (av == 2) ? 0 : 1;
  endfunction

  // R3, R4, R5 prediction
  function automatic int mpred(int mode, int av, int x, int y);
    int st, sl, h, v, b, c, a, p;
    st = 0; sl = 0; h = 0; v = 0;
    for (int i = 0; i < 16; i++) begin st += tp[i]; sl += lp[i]; end
    case (mode)
      0: return tp[x];
      1: return lp[y];
      2: begin
        if (av == 3) return (st + sl + 16) >>> 5;
        if (av == 2) return (st + 8) >>> 4;
        if (av == 1) return (sl + 8) >>> 4;
        return 128;
      end
      default: begin
        for (int i = 0; i < 8; i++) begin
          h += (i + 1) * (tp[8+i] - ((i == 7) ? cn : tp[6-i]));
          v += (i + 1) * (lp[8+i] - ((i == 7) ? cn : lp[6-i]));
        end
        b = (5 * h + 32) >>> 6;
        c = (5 * v + 32) >>> 6;
        a = 16 * (lp[15] + tp[15]);
        p = (a + b * (x - 7) + c * (y - 7) + 16) >>> 5;
        return (p < 0) ? 0 : (p > 255) ? 255 : p;
      end
    endcase
  endfunction

  task automatic load_data(input int kind);
    for (int i = 0; i < 16; i++) begin
      tp[i] = (kind == 0) ? 40 + 8 * i : i * 17;
      lp[i] = (kind == 0) ? 60 + 5 * i : 255 - i * 17;
    end
    cn = (kind == 0) ? 35 : 0;
    for (int i = 0; i < 256; i++)
      org[i] = (kind == 0) ? ((i % 16) * 13 + (i / 16) * 7 + 50) % 256 : ((i % 16) * 37 + (i / 16) * 91 + 11) & 255;
    @(negedge clk);
    nb_corner = 8'(cn);
    for (int i = 0; i < 32; i++) begin
      ref_we = 1'b1; ref_waddr = 5'(i);
      ref_wdata = 8'((i < 16) ? tp[i] : lp[i-16]);
      @(negedge clk);
    end
    ref_we = 1'b0;
    for (int i = 0; i < 256; i++) begin
      org_we = 1'b1; org_waddr = 8'(i); org_wdata = 8'(org[i]);
      @(negedge clk);
    end
    org_we = 1'b0;
  endtask

  task automatic run_mb(input string tag, input int av, input int costs[4], input bit bp, input bit inject);
    int bbuf, wsel, bmode, bcost, bidx, cyc, got, errs, lasterr, x, y, e, m;
    bit win;
    bbuf = 0; wsel = 0; bmode = 2; bcost = 0; bidx = 0; cyc = 0;
    @(negedge clk);
    start = 1'b1; avail = 2'(av);
    @(negedge clk);
    start = 1'b0;
    check({tag, " R1 launch busy"}, int'(busy), 1);
    for (int k = 0; k < mode_cnt(av); k++) begin
      m = mode_at(av, k);
      got = 0; errs = 0; lasterr = 0;
      while (got < 256) begin
        res_ready = bp ? ((cyc % 3) != 1) : 1'b1;
        cyc++;
        start = (inject && k == 0 && got == 100);
        #1;
        if (res_valid && res_ready) begin
          x = ((got >> 4) & 3) * 4 + (got & 3);
          y = ((got >> 6) & 3) * 4 + ((got >> 2) & 3);
          e = org[y * 16 + x] - mpred(m, av, x, y);
          resv[k][got] = e;
          if (int'($signed(res_data)) != e) errs++;
          if (res_last != (got == 255)) lasterr++;
          got++;
        end
        @(negedge clk);
      end
      res_ready = 1'b0; start = 1'b0;
      check($sformatf("%s R2 R6 mode %0d residual mismatches (R%0d)", tag, m,
            (m == 2) ? 3 : (m == 3) ? 5 : 4), errs, 0);
      check({tag, " R6 last flag"}, lasterr, 0);
      cost_valid = 1'b1; cost_data = 16'(costs[k]);
      @(negedge clk);
      cost_valid = 1'b0;
      win = (k == 0) || (costs[k] < bcost);
      if (win) begin bcost = costs[k]; bmode = m; bbuf = wsel; bidx = k; wsel = 1 - wsel; end
      else wsel = 1 - bbuf;
    end
    check({tag, " R10 done pulse"}, int'(done), 1);
    check({tag, " R8 best mode"}, int'(best_mode), bmode);
    check({tag, " R9 best buffer"}, int'(best_buf), bbuf);
    @(negedge clk);
    check({tag, " R10 done drops, idle"}, int'(done) + int'(busy), 0);
    errs = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a); #1;
      if (int'($signed(rd_data)) != resv[bidx][a]) errs++;
    end
    check({tag, " R9 readout of winner"}, errs, 0);
    repeat (3) @(negedge clk);
    check({tag, " R10 result held"}, int'(best_mode) * 2 + int'(best_buf), bmode * 2 + bbuf);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset busy", int'(busy), 0);
    check("R10 reset valid/done", int'(res_valid) + int'(done), 0);
    check("R10 reset best_mode DC", int'(best_mode), 2);
    check("R10 reset best_buf", int'(best_buf), 0);
    load_data(0);
    run_mb("full late winner", 3, '{300, 200, 250, 100}, 1'b0, 1'b0);
    run_mb("full ties R8", 3, '{100, 100, 100, 100}, 1'b1, 1'b0);
    run_mb("upper only", 2, '{80, 20, 0, 0}, 1'b0, 1'b0);
    run_mb("left only R1 busy start", 1, '{20, 80, 0, 0}, 1'b1, 1'b1);
    run_mb("none", 0, '{5, 0, 0, 0}, 1'b0, 1'b0);
    load_data(1);
    run_mb("plane clip R5", 3, '{9, 9, 9, 0}, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule